// File: doc/BRIEF.md
# Bus Error First-Capture Unit

This block collects error events from bus-side detection logic and presents them to an interrupt handler. Eight sticky cause bits record every error that has occurred since software last cleared them. A separate set of capture registers keeps the full context of a single error: the transaction address, 64 bits of data with 8 bits of data parity, and 4 bits of address parity. A 5-bit selector records which error kind that context belongs to.

Capture is governed by a two-state machine. In state `CAP_ARMED` the first cycle with any event pulse loads the capture registers and takes the transition *capture* to `CAP_LOCKED`. In `CAP_LOCKED` further events still set their cause bits but leave the captured context alone. A read of the captured-address register takes the transition *rearm* back to `CAP_ARMED`. No other transitions exist; each state otherwise holds. A handler should therefore read the captured address last.

Software reaches all registers over a simple 32-bit bus with a 3-bit word index and combinational read data. One interrupt line is asserted, one cycle late, while any cause bit is set together with its mask bit.

Top module: `err_cap_top`

## Requirements
- R1: Event input bit i sets cause bit i (word 0, bits 7:0) at the next clock edge. The bits are: 0 address out of range, 1 address parity, 2 burst to internal register, 3 access protection, 4 write protection, 5 cache protection, 6 write data parity, 7 read data parity.
- R2: A write to word 0 clears each cause bit whose write-data bit is 0 and leaves bits written with 1 unchanged. An event arriving in the same cycle as a clear leaves its bit set.
- R3: Word 0 bits 31:27 hold the index (0 to 7) of the captured event. If several events arrive together while armed, the lowest index is captured.
- R4: Only the first error is captured; while locked, later events do not change words 2 to 6 or the selector.
- R5: Only a read of word 2 (captured address) re-arms capture; reads of any other word do not.
- R6: Word 3 holds address parity in bits 7:4, all other bits zero. Word 4 holds data bits 31:0, word 5 data bits 63:32, and word 6 data parity in bits 7:0. Word 7 reads zero.
- R7: Word 1 bits 7:0 are the mask; a 1 enables the matching cause bit. `irq` equals the OR of cause AND mask as it stood one cycle earlier.
- R8: Events arriving while locked still set their cause bits.
- R9: After reset all words read zero, `irq` is low, and capture is armed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_i | input | 8 | Error event pulses, one per cause bit |
| evt_addr_i | input | 32 | Address of the erroring transaction |
| evt_data_i | input | 64 | Data of the erroring transaction |
| evt_dpar_i | input | 8 | Data parity sampled with the data |
| evt_apar_i | input | 4 | Address parity sampled with the address |
| reg_wr_i | input | 1 | Register write strobe |
| reg_rd_i | input | 1 | Register read strobe |
| reg_idx_i | input | 3 | Register word index |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data (combinational) |
| irq_o | output | 1 | Interrupt request |

## Verification
Read data is combinational, so each read result is sampled in the same cycle as its strobe, one time step after the inputs settle and before the edge at which a word-2 read re-arms. Cause, mask, capture and state changes take effect at the edge following the stimulus and are observed by reads in the next cycle. The interrupt is one register further downstream: it reflects cause and mask as they were before that edge, so the bench compares it after each edge against the model value computed before the model is advanced.

// File: rtl/err_cap_pkg.sv
package err_cap_pkg;

    typedef enum logic {
        CAP_ARMED  = 1'b0,
        CAP_LOCKED = 1'b1
    } cap_state_e;

    localparam int unsigned WORD_CAUSE = 0;
    localparam int unsigned WORD_MASK  = 1;
    localparam int unsigned WORD_ADDR  = 2;
    localparam int unsigned WORD_APAR  = 3;
    localparam int unsigned WORD_DLO   = 4;
    localparam int unsigned WORD_DHI   = 5;
    localparam int unsigned WORD_DPAR  = 6;

endpackage

// File: rtl/err_cap_fsm.sv
module err_cap_fsm
    import err_cap_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       any_evt,
    input  logic       rearm,
    output cap_state_e state,
    output logic       cap_en
);

    cap_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CAP_ARMED:  if (any_evt) state_d = CAP_LOCKED;
            CAP_LOCKED: if (rearm)   state_d = CAP_ARMED;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= CAP_ARMED;
        else        state_q <= state_d;
    end

    always_comb begin
        state  = state_q;
        cap_en = (state_q == CAP_ARMED) && any_evt;
    end

endmodule

// File: rtl/err_cap_store.sv
module err_cap_store #(
    parameter int unsigned NUM_ERR = 8,
    parameter int unsigned SEL_W   = 5,
    parameter int unsigned ADDR_W  = 32,
    parameter int unsigned DATA_W  = 64,
    parameter int unsigned DPAR_W  = 8,
    parameter int unsigned APAR_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cap_en,
    input  logic [NUM_ERR-1:0] evt,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] data,
    input  logic [DPAR_W-1:0] dpar,
    input  logic [APAR_W-1:0] apar,
    output logic [ADDR_W-1:0] cap_addr,
    output logic [DATA_W-1:0] cap_data,
    output logic [DPAR_W-1:0] cap_dpar,
    output logic [APAR_W-1:0] cap_apar,
    output logic [SEL_W-1:0]  sel
);

    logic [SEL_W-1:0] first_idx;

    // lowest set event index wins
    always_comb begin
        first_idx = '0;
        for (int i = NUM_ERR - 1; i >= 0; i--) begin
            if (evt[i]) first_idx = SEL_W'(i);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_addr <= '0;
            cap_data <= '0;
            cap_dpar <= '0;
            cap_apar <= '0;
            sel      <= '0;
        end else if (cap_en) begin
            cap_addr <= addr;
            cap_data <= data;
            cap_dpar <= dpar;
            cap_apar <= apar;
            sel      <= first_idx;
        end
    end

endmodule

// File: rtl/err_cap_cause.sv
module err_cap_cause #(
    parameter int unsigned NUM_ERR = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_ERR-1:0] evt,
    input  logic               clr_we,
    input  logic [NUM_ERR-1:0] keep_bits,
    input  logic               mask_we,
    input  logic [NUM_ERR-1:0] mask_wdata,
    output logic [NUM_ERR-1:0] cause,
    output logic [NUM_ERR-1:0] mask,
    output logic               irq
);

    logic [NUM_ERR-1:0] cause_d;

    always_comb begin
        cause_d = cause;
        if (clr_we) cause_d = cause_d & keep_bits;
        cause_d = cause_d | evt;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cause <= '0;
            mask  <= '0;
            irq   <= 1'b0;
        end else begin
            cause <= cause_d;
            if (mask_we) mask <= mask_wdata;
            irq <= |(cause & mask);
        end
    end

endmodule

// File: rtl/err_cap_top.sv
module err_cap_top
    import err_cap_pkg::*;
#(
    parameter int unsigned NUM_ERR = 8,
    parameter int unsigned SEL_W   = 5,
    parameter int unsigned ADDR_W  = 32,
    parameter int unsigned DATA_W  = 64,
    parameter int unsigned DPAR_W  = 8,
    parameter int unsigned APAR_W  = 4,
    parameter int unsigned IDX_W   = 3,
    parameter int unsigned BUS_W   = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_ERR-1:0] evt_i,
    input  logic [ADDR_W-1:0] evt_addr_i,
    input  logic [DATA_W-1:0] evt_data_i,
    input  logic [DPAR_W-1:0] evt_dpar_i,
    input  logic [APAR_W-1:0] evt_apar_i,
    input  logic              reg_wr_i,
    input  logic              reg_rd_i,
    input  logic [IDX_W-1:0]  reg_idx_i,
    input  logic [BUS_W-1:0]  reg_wdata_i,
    output logic [BUS_W-1:0]  reg_rdata_o,
    output logic              irq_o
);

    localparam int unsigned CAUSE_PAD = BUS_W - SEL_W - NUM_ERR;
    localparam int unsigned APAR_LSB  = 4;
    localparam int unsigned APAR_PAD  = BUS_W - APAR_W - APAR_LSB;
    localparam int unsigned HALF_W    = DATA_W / 2;

    cap_state_e        fsm_state;
    logic              cap_en;
    logic              rearm;
    logic [NUM_ERR-1:0] cause, mask;
    logic [ADDR_W-1:0] cap_addr;
    logic [DATA_W-1:0] cap_data;
    logic [DPAR_W-1:0] cap_dpar;
    logic [APAR_W-1:0] cap_apar;
    logic [SEL_W-1:0]  sel;
    logic              unused_wbits;

    assign rearm        = reg_rd_i && (reg_idx_i == IDX_W'(WORD_ADDR));
    assign unused_wbits = ^reg_wdata_i[BUS_W-1:NUM_ERR];

    err_cap_fsm u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .any_evt (|evt_i),
        .rearm   (rearm),
        .state   (fsm_state),
        .cap_en  (cap_en)
    );

    err_cap_store #(
        .NUM_ERR(NUM_ERR), .SEL_W(SEL_W), .ADDR_W(ADDR_W),
        .DATA_W(DATA_W), .DPAR_W(DPAR_W), .APAR_W(APAR_W)
    ) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .cap_en   (cap_en),
        .evt      (evt_i),
        .addr     (evt_addr_i),
        .data     (evt_data_i),
        .dpar     (evt_dpar_i),
        .apar     (evt_apar_i),
        .cap_addr (cap_addr),
        .cap_data (cap_data),
        .cap_dpar (cap_dpar),
        .cap_apar (cap_apar),
        .sel      (sel)
    );

    err_cap_cause #(.NUM_ERR(NUM_ERR)) u_cause (
        .clk        (clk),
        .rst_n      (rst_n),
        .evt        (evt_i),
        .clr_we     (reg_wr_i && (reg_idx_i == IDX_W'(WORD_CAUSE))),
        .keep_bits  (reg_wdata_i[NUM_ERR-1:0]),
        .mask_we    (reg_wr_i && (reg_idx_i == IDX_W'(WORD_MASK))),
        .mask_wdata (reg_wdata_i[NUM_ERR-1:0]),
        .cause      (cause),
        .mask       (mask),
        .irq        (irq_o)
    );

    always_comb begin
        reg_rdata_o = '0;
        unique case (reg_idx_i)
            IDX_W'(WORD_CAUSE): reg_rdata_o = {sel, {CAUSE_PAD{1'b0}}, cause};
            IDX_W'(WORD_MASK):  reg_rdata_o = BUS_W'(mask);
            IDX_W'(WORD_ADDR):  reg_rdata_o = BUS_W'(cap_addr);
            IDX_W'(WORD_APAR):  reg_rdata_o = {{APAR_PAD{1'b0}}, cap_apar, {APAR_LSB{1'b0}}};
            IDX_W'(WORD_DLO):   reg_rdata_o = BUS_W'(cap_data[HALF_W-1:0]);
            IDX_W'(WORD_DHI):   reg_rdata_o = BUS_W'(cap_data[DATA_W-1:HALF_W]);
            IDX_W'(WORD_DPAR):  reg_rdata_o = BUS_W'(cap_dpar);
            default:            reg_rdata_o = '0;
        endcase
    end

endmodule

// File: rtl/err_cap_chk.sv
module err_cap_chk
    import err_cap_pkg::*;
#(
    parameter int unsigned NUM_ERR = 8,
    parameter int unsigned SEL_W   = 5,
    parameter int unsigned ADDR_W  = 32,
    parameter int unsigned IDX_W   = 3
) (
    input logic               clk,
    input logic               rst_n,
    input cap_state_e         state,
    input logic [NUM_ERR-1:0] evt,
    input logic               reg_wr,
    input logic               reg_rd,
    input logic [IDX_W-1:0]   reg_idx,
    input logic [NUM_ERR-1:0] cause,
    input logic [NUM_ERR-1:0] mask,
    input logic [ADDR_W-1:0]  cap_addr,
    input logic [SEL_W-1:0]   sel,
    input logic               irq
);

    logic rd_addr, wr_cause;
    assign rd_addr  = reg_rd && (reg_idx == IDX_W'(WORD_ADDR));
    assign wr_cause = reg_wr && (reg_idx == IDX_W'(WORD_CAUSE));

    p_set_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (|evt) |=> ((cause & $past(evt)) == $past(evt)));

    p_sticky_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_cause |=> ((cause & $past(cause)) == $past(cause)));

    p_sel_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
        sel < SEL_W'(NUM_ERR));

    p_lock_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == CAP_LOCKED && !rd_addr) |=> ($stable(cap_addr) && $stable(sel)));

    p_capture_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == CAP_ARMED && (|evt)) |=> (state == CAP_LOCKED));

    p_rearm_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == CAP_LOCKED && rd_addr) |=> (state == CAP_ARMED));

    p_irq_on_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ((cause & mask) != '0) |=> irq);

    p_irq_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ((cause & mask) == '0) |=> !irq);

endmodule

bind err_cap_top err_cap_chk #(
    .NUM_ERR(NUM_ERR), .SEL_W(SEL_W), .ADDR_W(ADDR_W), .IDX_W(IDX_W)
) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .state    (fsm_state),
    .evt      (evt_i),
    .reg_wr   (reg_wr_i),
    .reg_rd   (reg_rd_i),
    .reg_idx  (reg_idx_i),
    .cause    (cause),
    .mask     (mask),
    .cap_addr (cap_addr),
    .sel      (sel),
    .irq      (irq_o)
);

// File: tb/err_cap_top_tb_top.sv
`timescale 1ns/1ps
module err_cap_top_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  evt = '0;
    logic [31:0] e_addr = '0;
    logic [63:0] e_data = '0;
    logic [7:0]  e_dpar = '0;
    logic [3:0]  e_apar = '0;
    logic        reg_wr = 1'b0, reg_rd = 1'b0;
    logic [2:0]  reg_idx = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] rdata;
    logic        irq;

    int n_chk = 0, n_err = 0;
    bit done = 1'b0;

    // bench model
    logic [7:0]  m_cause = '0, m_mask = '0, m_dpar = '0;
    logic [4:0]  m_sel = '0;
    logic [31:0] m_addr = '0;
    logic [63:0] m_data = '0;
    logic [3:0]  m_apar = '0;
    logic        m_locked = 1'b0, m_irq = 1'b0;

    always #2.5 clk = ~clk;

    err_cap_top dut_i (
        .clk(clk), .rst_n(rst_n), .evt_i(evt), .evt_addr_i(e_addr),
        .evt_data_i(e_data), .evt_dpar_i(e_dpar), .evt_apar_i(e_apar),
        .reg_wr_i(reg_wr), .reg_rd_i(reg_rd), .reg_idx_i(reg_idx),
        .reg_wdata_i(reg_wdata), .reg_rdata_o(rdata), .irq_o(irq)
    );

    function automatic logic [31:0] exp_read(input logic [2:0] idx);
        case (idx)
            3'd0: return {m_sel, 19'b0, m_cause};
            3'd1: return {24'b0, m_mask};
            3'd2: return m_addr;
            3'd3: return {24'b0, m_apar, 4'b0};
            3'd4: return m_data[31:0];
            3'd5: return m_data[63:32];
            3'd6: return {24'b0, m_dpar};
            default: return 32'b0;
        endcase
    endfunction

    function automatic logic [4:0] lowest(input logic [7:0] v);
        for (int i = 0; i < 8; i++) if (v[i]) return 5'(i);
        return 5'd0;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic step(input logic [7:0] ev, input logic [31:0] ad, input logic [63:0] dt,
                        input logic [7:0] dp, input logic [3:0] ap, input bit wr, input bit rd,
                        input logic [2:0] idx, input logic [31:0] wd, input string req);
        logic irq_n;
        evt = ev; e_addr = ad; e_data = dt; e_dpar = dp; e_apar = ap;
        reg_wr = wr; reg_rd = rd; reg_idx = idx; reg_wdata = wd;
        #1;
        if (rd) check(req, rdata, exp_read(idx));
        @(posedge clk);
        irq_n = |(m_cause & m_mask);
        if (!m_locked && ev != 8'h00) begin
            m_addr = ad; m_data = dt; m_dpar = dp; m_apar = ap;
            m_sel = lowest(ev); m_locked = 1'b1;
        end else if (m_locked && rd && idx == 3'd2) begin
            m_locked = 1'b0;
        end
        if (wr && idx == 3'd0) m_cause = m_cause & wd[7:0];
        m_cause = m_cause | ev;
        if (wr && idx == 3'd1) m_mask = wd[7:0];
        m_irq = irq_n;
        @(negedge clk);
        check("R7 irq", {31'b0, irq}, {31'b0, m_irq});
        evt = '0; reg_wr = 1'b0; reg_rd = 1'b0;
    endtask

    task automatic rd_word(input logic [2:0] idx, input string req);
        step(8'h00, 32'h0, 64'h0, 8'h0, 4'h0, 1'b0, 1'b1, idx, 32'h0, req);
    endtask

    task automatic wr_word(input logic [2:0] idx, input logic [31:0] wd, input string req);
        step(8'h00, 32'h0, 64'h0, 8'h0, 4'h0, 1'b1, 1'b0, idx, wd, req);
    endtask

    task automatic fire(input logic [7:0] ev, input logic [31:0] ad, input string req);
        step(ev, ad, {~ad, ad ^ 32'h5A5A_0F0F}, ad[15:8], ad[3:0], 1'b0, 1'b0, 3'd0, 32'h0, req);
    endtask

    task automatic summary;
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        summary();
    end

    initial begin
        void'($urandom(32'hC0FFEE11));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R9: reset state
        for (int i = 0; i < 8; i++) rd_word(3'(i), "R9");

        // R1 / R6: first capture with access-protection event (bit 3)
        fire(8'h08, 32'h1234_5678, "R1");
        rd_word(3'd0, "R1 cause and R3 sel");
        for (int i = 3; i < 8; i++) rd_word(3'(i), "R6 layout");
        // R8 / R4: later event while locked
        fire(8'h02, 32'hDEAD_BEEF, "R8");
        rd_word(3'd0, "R8 cause");
        rd_word(3'd4, "R4 data held");
        // R5: non-address read does not re-arm
        rd_word(3'd6, "R5");
        fire(8'h01, 32'h0BAD_0001, "R5");
        rd_word(3'd0, "R4 sel held");
        rd_word(3'd2, "R4 addr held / R5 rearm");
        // R3: simultaneous events, lowest wins
        fire(8'h28, 32'hA5A5_0003, "R3");
        rd_word(3'd0, "R3 priority");
        rd_word(3'd2, "R3 addr");
        // R2: clear by zero, ones ignored
        wr_word(3'd0, 32'hFFFF_FFDF, "R2");
        rd_word(3'd0, "R2 clear bit5");
        wr_word(3'd0, 32'hFFFF_FFFF, "R2");
        rd_word(3'd0, "R2 ones no effect");
        step(8'h08, 32'h77, 64'h1, 8'h1, 4'h1, 1'b1, 1'b0, 3'd0, 32'h0, "R2");
        rd_word(3'd0, "R2 event beats clear");
        // R7: mask enables interrupt
        wr_word(3'd1, 32'h0000_0010, "R7");
        rd_word(3'd1, "R7 mask");
        wr_word(3'd1, 32'h0000_0008, "R7");
        rd_word(3'd1, "R7 mask");
        wr_word(3'd0, 32'h0, "R7");
        rd_word(3'd0, "R7 cleared");
        // R3: top index alone
        rd_word(3'd2, "R5 rearm");
        fire(8'h80, 32'hFEED_0080, "R3");
        rd_word(3'd0, "R3 sel 7");

        // constrained random
        for (int n = 0; n < 4000; n++) begin
            logic [7:0]  ev;
            logic [2:0]  idx;
            logic [31:0] wd;
            bit          wr, rd;
            ev  = (($urandom % 6) == 0) ? 8'($urandom) : 8'h00;
            idx = 3'($urandom);
            wr  = (($urandom % 5) == 0) && (idx <= 3'd1);
            rd  = !wr && (($urandom % 2) == 0);
            wd  = (idx == 3'd0) ? ($urandom | 32'hFFFF_FF00) : $urandom;
            step(ev, $urandom, {$urandom, $urandom}, 8'($urandom), 4'($urandom),
                 wr, rd, idx, wd, (idx == 3'd0) ? "R2 rnd cause" : "R6 rnd word");
        end
        summary();
    end

endmodule